// File: doc/BRIEF.md
# Command Stream Method Decoder

This block sits behind a command fetcher and turns a stream of 32-bit command words into register writes. Each header word announces how many payload words follow and where they go. The block then emits one write per payload word, made of a subchannel, a byte address and a data word. Three header kinds are handled. Incrementing bursts step the address by four on each word. Non-incrementing bursts send every word to one address. Immediate headers carry their own data and take no payload.

Alongside the write port, the block watches its own write stream for an inline launch burst. In that burst, two words give a 64-bit descriptor pointer and 64 data words make up a 256-byte launch descriptor. The block collects the data words into a descriptor register. After the final word it raises a one-cycle launch strobe, and it presents the grid size and the block size taken from fixed descriptor words. The consumer of the write port and of the launch port carries out the work; this block only decodes.

Top module: `cmd_method_decoder`

## Requirements
- R1: A header word is split as opcode = bits 31:29, count = bits 28:16, subchannel = bits 15:13 and word offset = bits 11:0. Every emitted write carries that subchannel and the byte address offset*4 (14 bits).
- R2: Opcode 1 (incrementing) emits `count` writes carrying the payload words in order. The first goes to offset*4 and each later one goes 4 bytes higher.
- R3: Opcode 4 (immediate) consumes no payload and emits exactly one write to offset*4, whose data is the 13-bit count zero-extended to 32 bits.
- R4: Opcode 3 (non-incrementing) emits `count` writes, all to offset*4.
- R5: A header with opcode 1 or 3 and a count of 0 emits no write, and the next accepted word is decoded as a header.
- R6: The write for an accepted word is presented in the cycle after the word is accepted. A cycle with no accepted word yields no write in the following cycle. Idle gaps (cmd_valid low) inside a burst do not disturb it.
- R7: A write to byte address 0x318 loads launch_ptr[31:0], and a write to 0x31C loads launch_ptr[63:32]. A write to 0x320+4*i, for i from 0 to 63, loads descriptor word i, which appears on launch_desc bits 32*i+31:32*i.
- R8: launch_strobe is high for exactly one cycle, namely the cycle after the write to 0x41C (descriptor word 63) is presented. The descriptor register does not change in a cycle that follows one with no write.
- R9: launch_grid shows descriptor word 12, and launch_block shows descriptor word 18.
- R10: A header with any other opcode (0, 2, 5, 6 or 7) is consumed as a single word and emits no write. It sets err_flag, which then stays high until reset.
- R11: During reset cmd_ready is low, and mw_valid, err_flag and launch_strobe are low. cmd_ready is high from the cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Decoder accepts a word |
| cmd_word | input | 32 | Command word (header or payload) |
| mw_valid | output | 1 | Register write valid |
| mw_subch | output | 3 | Subchannel of the write |
| mw_addr | output | 14 | Byte address of the write |
| mw_data | output | 32 | Data of the write |
| err_flag | output | 1 | Sticky unknown-opcode flag |
| launch_strobe | output | 1 | One-cycle descriptor-complete pulse |
| launch_ptr | output | 64 | Inline descriptor pointer {high, low} |
| launch_desc | output | 2048 | Captured descriptor, word i at bits 32*i+31:32*i |
| launch_grid | output | 32 | Descriptor word 12 |
| launch_block | output | 32 | Descriptor word 18 |

## Verification
The bench builds the decoder with its default parameters: 64 descriptor words, pointer offset 0x318, grid word 12 and block word 18. With these values, a complete 66-word launch burst, including a mid-burst idle gap, runs in well under a hundred cycles. That makes every descriptor slot, the last-word strobe and the grid and block taps observable at full size. Short bursts of each header kind then exercise the address stepping, the zero-count case, immediate data and the sticky error, each against hand-computed addresses and data.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;

    localparam int WORD_W  = 32;
    localparam int OP_W    = 3;
    localparam int CNT_W   = 13;
    localparam int SUB_W   = 3;
    localparam int OFS_W   = 12;
    localparam int BADDR_W = OFS_W + 2;
    localparam int STEP_B  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_INCR  = 3'd1,
        OP_FIXED = 3'd3,
        OP_IMM   = 3'd4
    } op_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [CNT_W-1:0] cnt;
        logic [SUB_W-1:0] sub;
        logic             spare;
        logic [OFS_W-1:0] ofs;
    } hdr_t;

    typedef struct packed {
        logic               vld;
        logic [SUB_W-1:0]   sub;
        logic [BADDR_W-1:0] addr;
        logic [WORD_W-1:0]  data;
    } mwrite_t;

    function automatic logic [BADDR_W-1:0] ofs_to_byte(input logic [OFS_W-1:0] ofs);
        return {ofs, 2'b00};
    endfunction

endpackage

// File: rtl/cmdec_hdr_walker.sv
module cmdec_hdr_walker
    import cmdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_fire,
    input  logic [WORD_W-1:0] in_word,
    output mwrite_t           wr,
    output logic              busy,
    output logic              err
);

    typedef enum logic {S_HDR, S_PAY} walk_e;

    walk_e              st;
    logic [CNT_W-1:0]   left;
    logic               step_en;
    logic [SUB_W-1:0]   sub_q;
    logic [BADDR_W-1:0] addr_q;
    hdr_t               h;

    assign h    = hdr_t'(in_word);
    assign busy = (st == S_PAY);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_HDR;
            left    <= '0;
            step_en <= 1'b0;
            sub_q   <= '0;
            addr_q  <= '0;
            wr      <= '0;
            err     <= 1'b0;
        end else begin
            wr.vld <= 1'b0;
            if (in_fire) begin
                if (st == S_HDR) begin
                    case (h.op)
                        OP_INCR, OP_FIXED: begin
                            if (h.cnt != '0) st <= S_PAY;
                            left    <= h.cnt;
                            step_en <= (h.op == OP_INCR);
                            sub_q   <= h.sub;
                            addr_q  <= ofs_to_byte(h.ofs);
                        end
                        OP_IMM: begin
                            wr.vld  <= 1'b1;
                            wr.sub  <= h.sub;
                            wr.addr <= ofs_to_byte(h.ofs);
                            wr.data <= WORD_W'(h.cnt);
                        end
                        default: err <= 1'b1;
                    endcase
                end else begin
                    wr.vld  <= 1'b1;
                    wr.sub  <= sub_q;
                    wr.addr <= addr_q;
                    wr.data <= in_word;
                    if (step_en) addr_q <= addr_q + BADDR_W'(STEP_B);
                    left <= left - CNT_W'(1);
                    if (left == CNT_W'(1)) st <= S_HDR;
                end
            end
        end
    end

endmodule

// File: rtl/cmdec_desc_grab.sv
module cmdec_desc_grab
    import cmdec_pkg::*;
#(
    parameter int                 DESC_WORDS = 64,
    parameter logic [BADDR_W-1:0] PTR_BASE   = 14'h318,
    parameter int                 GRID_IDX   = 12,
    parameter int                 BLOCK_IDX  = 18
) (
    input  logic                         clk,
    input  logic                         rst,
    input  mwrite_t                      wr,
    output logic [WORD_W*DESC_WORDS-1:0] desc_flat,
    output logic [2*WORD_W-1:0]          desc_ptr,
    output logic                         launch,
    output logic [WORD_W-1:0]            grid,
    output logic [WORD_W-1:0]            block
);

    localparam logic [BADDR_W-1:0] PTR_HI    = PTR_BASE + BADDR_W'(STEP_B);
    localparam logic [BADDR_W-1:0] DATA_BASE = PTR_BASE + BADDR_W'(2*STEP_B);
    localparam logic [BADDR_W-1:0] LAST_ADDR = DATA_BASE + BADDR_W'(STEP_B*(DESC_WORDS-1));

    logic [WORD_W-1:0] ptr_lo, ptr_hi;

    for (genvar i = 0; i < DESC_WORDS; i++) begin : g_slot
        localparam logic [BADDR_W-1:0] SLOT_ADDR = DATA_BASE + BADDR_W'(STEP_B*i);
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                               q <= '0;
            else if (wr.vld && wr.addr == SLOT_ADDR) q <= wr.data;
        end
        assign desc_flat[i*WORD_W +: WORD_W] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_lo <= '0;
            ptr_hi <= '0;
            launch <= 1'b0;
        end else begin
            if (wr.vld && wr.addr == PTR_BASE) ptr_lo <= wr.data;
            if (wr.vld && wr.addr == PTR_HI)   ptr_hi <= wr.data;
            launch <= wr.vld && (wr.addr == LAST_ADDR);
        end
    end

    assign desc_ptr = {ptr_hi, ptr_lo};
    assign grid     = desc_flat[GRID_IDX*WORD_W +: WORD_W];
    assign block    = desc_flat[BLOCK_IDX*WORD_W +: WORD_W];

endmodule

// File: rtl/cmd_method_decoder.sv
module cmd_method_decoder
    import cmdec_pkg::*;
#(
    parameter int                 DESC_WORDS  = 64,
    parameter logic [BADDR_W-1:0] DESC_PTR_OFS = 14'h318,
    parameter int                 GRID_WORD   = 12,
    parameter int                 BLOCK_WORD  = 18
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  logic [WORD_W-1:0]            cmd_word,
    output logic                         mw_valid,
    output logic [SUB_W-1:0]             mw_subch,
    output logic [BADDR_W-1:0]           mw_addr,
    output logic [WORD_W-1:0]            mw_data,
    output logic                         err_flag,
    output logic                         launch_strobe,
    output logic [2*WORD_W-1:0]          launch_ptr,
    output logic [WORD_W*DESC_WORDS-1:0] launch_desc,
    output logic [WORD_W-1:0]            launch_grid,
    output logic [WORD_W-1:0]            launch_block
);

    mwrite_t wr_s;
    logic    parse_busy;
    logic    ready_q;

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= 1'b1;
    end
    assign cmd_ready = ready_q;

    cmdec_hdr_walker walk_i (
        .clk     (clk),
        .rst     (rst),
        .in_fire (cmd_valid && ready_q),
        .in_word (cmd_word),
        .wr      (wr_s),
        .busy    (parse_busy),
        .err     (err_flag)
    );

    cmdec_desc_grab #(
        .DESC_WORDS (DESC_WORDS),
        .PTR_BASE   (DESC_PTR_OFS),
        .GRID_IDX   (GRID_WORD),
        .BLOCK_IDX  (BLOCK_WORD)
    ) grab_i (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_s),
        .desc_flat (launch_desc),
        .desc_ptr  (launch_ptr),
        .launch    (launch_strobe),
        .grid      (launch_grid),
        .block     (launch_block)
    );

    assign mw_valid = wr_s.vld;
    assign mw_subch = wr_s.sub;
    assign mw_addr  = wr_s.addr;
    assign mw_data  = wr_s.data;

endmodule

// File: rtl/cmdec_checker.sv
module cmdec_checker #(
    parameter int          DESC_W    = 2048,
    parameter logic [13:0] LAST_ADDR = 14'h41C
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [31:0]       cmd_word,
    input logic              mw_valid,
    input logic [13:0]       mw_addr,
    input logic [31:0]       mw_data,
    input logic              err_flag,
    input logic              launch_strobe,
    input logic [DESC_W-1:0] launch_desc,
    input logic              busy
);

    logic fire;
    assign fire = cmd_valid && cmd_ready;

    // R3: immediate header yields one write carrying the count
    assert_imm_write_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && !busy && cmd_word[31:29] == 3'd4) |=>
            (mw_valid && mw_data == {19'd0, $past(cmd_word[28:16])}
                      && mw_addr == {$past(cmd_word[11:0]), 2'b00}));

    // R6: an accepted payload word appears on the write port next cycle
    assert_payload_write_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && busy) |=> (mw_valid && mw_data == $past(cmd_word)));

    // R6: no accepted word, no write
    assert_no_spurious_write_R6: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !mw_valid);

    // R10: error flag is sticky
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R10: error rises only after a header with an unknown opcode
    assert_err_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(fire && !busy && cmd_word[31:29] != 3'd1
                                  && cmd_word[31:29] != 3'd3 && cmd_word[31:29] != 3'd4));

    // R8: strobe follows a write to the last descriptor slot
    assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (rst)
        launch_strobe |-> $past(mw_valid && mw_addr == LAST_ADDR));

    // R8: descriptor holds when no write was presented
    assert_desc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !mw_valid |=> $stable(launch_desc));

endmodule

bind cmd_method_decoder cmdec_checker #(
    .DESC_W    (2048),
    .LAST_ADDR (14'h41C)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_word      (cmd_word),
    .mw_valid      (mw_valid),
    .mw_addr       (mw_addr),
    .mw_data       (mw_data),
    .err_flag      (err_flag),
    .launch_strobe (launch_strobe),
    .launch_desc   (launch_desc),
    .busy          (parse_busy)
);

// File: tb/cmd_method_decoder_tb_top.sv
`timescale 1ns/1ps
module cmd_method_decoder_tb_top;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [31:0]   cmd_word = '0;
    logic          mw_valid;
    logic [2:0]    mw_subch;
    logic [13:0]   mw_addr;
    logic [31:0]   mw_data;
    logic          err_flag;
    logic          launch_strobe;
    logic [63:0]   launch_ptr;
    logic [2047:0] launch_desc;
    logic [31:0]   launch_grid;
    logic [31:0]   launch_block;

    int  nvec = 0;
    int  nerr = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    cmd_method_decoder dut_i (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_word      (cmd_word),
        .mw_valid      (mw_valid),
        .mw_subch      (mw_subch),
        .mw_addr       (mw_addr),
        .mw_data       (mw_data),
        .err_flag      (err_flag),
        .launch_strobe (launch_strobe),
        .launch_ptr    (launch_ptr),
        .launch_desc   (launch_desc),
        .launch_grid   (launch_grid),
        .launch_block  (launch_block)
    );

    function automatic logic [31:0] hdr(input logic [2:0] op, input logic [12:0] cnt,
                                        input logic [2:0] sub, input logic [11:0] ofs);
        return {op, cnt, sub, 1'b0, ofs};
    endfunction

    function automatic logic [31:0] desc_val(input int i);
        if (i == 12) return 32'd4096;
        if (i == 18) return 32'd256;
        return 32'hD00D_0000 + i;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic step(input logic v, input logic [31:0] w);
        cmd_valid = v;
        cmd_word  = w;
        @(negedge clk);
    endtask

    task automatic expect_wr(input string req, input logic [2:0] sub,
                             input logic [13:0] addr, input logic [31:0] data);
        chk(req, "mw_valid", 64'(mw_valid), 64'd1);
        chk(req, "mw_subch", 64'(mw_subch), 64'(sub));
        chk(req, "mw_addr",  64'(mw_addr),  64'(addr));
        chk(req, "mw_data",  64'(mw_data),  64'(data));
    endtask

    task automatic expect_none(input string req);
        chk(req, "mw_valid idle", 64'(mw_valid), 64'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", "ready in reset", 64'(cmd_ready), 64'd0);
        chk("R11", "valid in reset", 64'(mw_valid), 64'd0);
        chk("R11", "err in reset", 64'(err_flag), 64'd0);
        chk("R11", "strobe in reset", 64'(launch_strobe), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "ready after reset", 64'(cmd_ready), 64'd1);
    endtask

    task automatic t_incr();
        step(1'b1, hdr(3'd1, 13'd3, 3'd5, 12'h010));
        expect_none("R2");
        step(1'b1, 32'hAAAA_0001); expect_wr("R2", 3'd5, 14'h040, 32'hAAAA_0001);
        step(1'b1, 32'hAAAA_0002); expect_wr("R2", 3'd5, 14'h044, 32'hAAAA_0002);
        step(1'b1, 32'hAAAA_0003); expect_wr("R1", 3'd5, 14'h048, 32'hAAAA_0003);
        step(1'b0, 32'h0);         expect_none("R6");
    endtask

    task automatic t_fixed();
        step(1'b1, hdr(3'd3, 13'd2, 3'd1, 12'h020));
        expect_none("R4");
        step(1'b1, 32'h1111_2222); expect_wr("R4", 3'd1, 14'h080, 32'h1111_2222);
        step(1'b1, 32'h3333_4444); expect_wr("R4", 3'd1, 14'h080, 32'h3333_4444);
        step(1'b0, 32'h0);         expect_none("R4");
    endtask

    task automatic t_immediate();
        step(1'b1, hdr(3'd4, 13'h1ABC, 3'd2, 12'h005));
        expect_wr("R3", 3'd2, 14'h014, 32'h0000_1ABC);
        step(1'b0, 32'h0);
        expect_none("R3");
    endtask

    task automatic t_zero_count();
        step(1'b1, hdr(3'd1, 13'd0, 3'd0, 12'h030));
        expect_none("R5");
        step(1'b1, hdr(3'd4, 13'h0077, 3'd3, 12'h0FF));
        expect_wr("R5", 3'd3, 14'h3FC, 32'h0000_0077);
        step(1'b0, 32'h0);
    endtask

    task automatic t_unknown();
        chk("R10", "err before", 64'(err_flag), 64'd0);
        step(1'b1, hdr(3'd6, 13'd5, 3'd1, 12'h040));
        expect_none("R10");
        chk("R10", "err set", 64'(err_flag), 64'd1);
        step(1'b1, hdr(3'd4, 13'd9, 3'd4, 12'h001));
        expect_wr("R10", 3'd4, 14'h004, 32'd9);
        chk("R10", "err sticky", 64'(err_flag), 64'd1);
        step(1'b0, 32'h0);
    endtask

    task automatic t_launch();
        logic [63:0] saved;
        step(1'b1, hdr(3'd1, 13'd66, 3'd0, 12'h0C6));
        expect_none("R7");
        step(1'b1, 32'h1234_5000); expect_wr("R7", 3'd0, 14'h318, 32'h1234_5000);
        step(1'b1, 32'h0000_00AB); expect_wr("R7", 3'd0, 14'h31C, 32'h0000_00AB);
        for (int i = 0; i < 64; i++) begin
            if (i == 30) begin
                step(1'b0, 32'hFFFF_FFFF);
                expect_none("R6");
            end
            step(1'b1, desc_val(i));
            expect_wr("R7", 3'd0, 14'(14'h320 + 4*i), desc_val(i));
            chk("R8", "strobe early", 64'(launch_strobe), 64'd0);
        end
        step(1'b0, 32'h0);
        chk("R8", "strobe high", 64'(launch_strobe), 64'd1);
        step(1'b0, 32'h0);
        chk("R8", "strobe one cycle", 64'(launch_strobe), 64'd0);
        chk("R7", "launch_ptr", launch_ptr, 64'h0000_00AB_1234_5000);
        for (int i = 0; i < 64; i++)
            chk("R7", $sformatf("desc word %0d", i), 64'(launch_desc[i*32 +: 32]), 64'(desc_val(i)));
        chk("R9", "grid", 64'(launch_grid), 64'd4096);
        chk("R9", "block", 64'(launch_block), 64'd256);
        saved = 64'(launch_desc[5*32 +: 32]);
        step(1'b1, hdr(3'd4, 13'd1, 3'd0, 12'h010));
        step(1'b0, 32'h0);
        step(1'b0, 32'h0);
        chk("R8", "desc holds", 64'(launch_desc[5*32 +: 32]), saved);
        chk("R8", "no strobe", 64'(launch_strobe), 64'd0);
        chk("R9", "grid holds", 64'(launch_grid), 64'd4096);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_incr();
        t_fixed();
        t_immediate();
        t_zero_count();
        t_unknown();
        t_launch();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nvec++;
            nerr++;
            $display("FAIL R6 watchdog: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule